// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a four-line, fully associative store that sits beside a direct-mapped data cache and catches the lines that cache throws out. When the cache misses, its controller presents the missing line address on the lookup port. Along with it, the controller offers the line the refill will displace from the indexed set, if that set holds one. Every entry compares its stored line address against the lookup address in parallel. A hit returns the stored line and its dirty state. The offered displaced line then takes over the very entry that hit, so the two lines trade places in one operation and nothing goes to the next level.

When no entry matches, the block raises a request to the next level for the missing line. The displaced line is written into a free entry, choosing the lowest-numbered free slot first. If all four entries are in use, the least recently filled entry is replaced instead. A replaced entry that is dirty leaves through the write-back port in the same response cycle. All responses are registered and appear exactly one cycle after the lookup.

Because the cache array stays direct-mapped, its hit path is untouched. Lines that collide in one set can still be recovered from the buffer without a trip downstream.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is empty: no output is active, and any lookup then misses.
- R2: A lookup whose address matches no valid entry produces, in the following cycle, rsp_valid=1, rsp_hit=0, nl_req_valid=1 and nl_req_addr equal to the lookup address.
- R3: A lookup whose address matches a valid entry produces, in the following cycle, rsp_valid=1, rsp_hit=1, rsp_data and rsp_dirty equal to the stored line, and nl_req_valid=0.
- R4: On a hit with a displaced line offered (lk_ev_valid=1), the displaced line replaces the matching entry. A later lookup of the displaced address hits with its data and dirty flag, and a later lookup of the old address misses.
- R5: On a hit with no displaced line offered, the matching entry is freed, and a later lookup of that address misses.
- R6: On a miss with a displaced line offered and a free entry available, the line is stored without any write-back. The buffer holds up to four lines at once.
- R7: On a miss with a displaced line offered and all four entries valid, the entry least recently written (by insertion or swap) is replaced.
- R8: When R7 replaces a dirty entry, wb_valid=1 with that entry's address and data is presented in the same cycle as the miss response. A clean replaced entry causes no write-back.
- R9: A displaced line offered while lk_valid=0 is ignored: no output is raised, and it is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request from the cache controller on a cache miss |
| lk_addr | input | ADDR_W | Line address being looked up |
| lk_ev_valid | input | 1 | A displaced line accompanies the lookup |
| lk_ev_addr | input | ADDR_W | Line address of the displaced line |
| lk_ev_data | input | LINE_W | Data of the displaced line |
| lk_ev_dirty | input | 1 | Displaced line is modified |
| rsp_valid | output | 1 | Lookup response valid, one cycle after lk_valid |
| rsp_hit | output | 1 | The looked-up line was found in the buffer |
| rsp_data | output | LINE_W | Returned line data on a hit |
| rsp_dirty | output | 1 | Returned line is modified |
| nl_req_valid | output | 1 | Request of the missing line from the next level |
| nl_req_addr | output | ADDR_W | Line address requested from the next level |
| wb_valid | output | 1 | Dirty line leaving the buffer towards the next level |
| wb_addr | output | ADDR_W | Line address of the written-back line |
| wb_data | output | LINE_W | Data of the written-back line |

## Verification
The hardest state to reach is a full buffer whose oldest entry is dirty, right after swaps have changed the age order away from insertion order. Only a miss that offers a fresh displaced line exposes that entry, through the write-back port. The bench gets there with a directed sequence of four fills, two swaps and three further fills, with expected write-backs worked out by hand. It then runs a long sweep that models a four-set direct-mapped cache over sixteen line addresses with random reads and writes. This sweep produces conflict misses, swaps, dirty evictions and freed entries in many orders, each compared against a behavioural model of the buffer.

// File: rtl/vb_pkg.sv
package vb_pkg;
    localparam int unsigned VB_DEF_ENTRIES = 4;
    localparam int unsigned VB_DEF_ADDR_W  = 12;
    localparam int unsigned VB_DEF_LINE_W  = 32;

    function automatic int unsigned vb_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 12,
    parameter int unsigned IW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          vld,
    input  logic [N-1:0][AW-1:0]  tags,
    input  logic [AW-1:0]         key,
    output logic                  hit,
    output logic [IW-1:0]         idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) idx = IW'(i);
        end
    end

    assign hit = |hit_vec;

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  vld,
    output logic [IW-1:0] victim_idx
);
    typedef struct packed {
        logic [N-1:0][IW-1:0] rank;
    } lru_state_t;

    lru_state_t st_q, st_d;
    logic       found_free;

    always_comb begin
        st_d = st_q;
        if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    st_d.rank[i] = '0;
                else if (st_q.rank[i] < st_q.rank[touch_idx])
                    st_d.rank[i] = st_q.rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_idx = '0;
        found_free = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (st_q.rank[i] == IW'(N - 1)) victim_idx = IW'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (!vld[i] && !found_free) begin
                victim_idx = IW'(i);
                found_free = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) st_q.rank[i] <= IW'(i);
        end else begin
            st_q <= st_d;
        end
    end

    logic [N-1:0] rank_seen;
    always_comb begin
        rank_seen = '0;
        for (int i = 0; i < N; i++) rank_seen[st_q.rank[i]] = 1'b1;
    end

    // R7
    rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &rank_seen);
endmodule

// File: rtl/victim_buf.sv
module victim_buf
    import vb_pkg::*;
#(
    parameter int unsigned ENTRIES = VB_DEF_ENTRIES,
    parameter int unsigned ADDR_W  = VB_DEF_ADDR_W,
    parameter int unsigned LINE_W  = VB_DEF_LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_ev_valid,
    input  logic [ADDR_W-1:0] lk_ev_addr,
    input  logic [LINE_W-1:0] lk_ev_data,
    input  logic              lk_ev_dirty,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              nl_req_valid,
    output logic [ADDR_W-1:0] nl_req_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data
);
    localparam int unsigned IW = vb_idx_w(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0]             dty;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][LINE_W-1:0] dat;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic [LINE_W-1:0]              rsp_data;
        logic                           rsp_dirty;
        logic                           nl_valid;
        logic [ADDR_W-1:0]              nl_addr;
        logic                           wb_valid;
        logic [ADDR_W-1:0]              wb_addr;
        logic [LINE_W-1:0]              wb_data;
    } vb_state_t;

    vb_state_t st_q, st_d;

    logic          m_hit;
    logic [IW-1:0] m_idx;
    logic [IW-1:0] victim_idx;
    logic          touch;
    logic [IW-1:0] touch_idx;

    vb_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_match (
        .clk   (clk),
        .rst_n (rst_n),
        .vld   (st_q.vld),
        .tags  (st_q.tag),
        .key   (lk_addr),
        .hit   (m_hit),
        .idx   (m_idx)
    );

    vb_lru #(.N(ENTRIES), .IW(IW)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .vld        (st_q.vld),
        .victim_idx (victim_idx)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_hit   = 1'b0;
        st_d.nl_valid  = 1'b0;
        st_d.wb_valid  = 1'b0;
        touch          = 1'b0;
        touch_idx      = '0;
        if (lk_valid) begin
            st_d.rsp_valid = 1'b1;
            if (m_hit) begin
                st_d.rsp_hit   = 1'b1;
                st_d.rsp_data  = st_q.dat[m_idx];
                st_d.rsp_dirty = st_q.dty[m_idx];
                if (lk_ev_valid) begin
                    st_d.vld[m_idx] = 1'b1;
                    st_d.tag[m_idx] = lk_ev_addr;
                    st_d.dat[m_idx] = lk_ev_data;
                    st_d.dty[m_idx] = lk_ev_dirty;
                    touch           = 1'b1;
                    touch_idx       = m_idx;
                end else begin
                    st_d.vld[m_idx] = 1'b0;
                end
            end else begin
                st_d.rsp_data  = '0;
                st_d.rsp_dirty = 1'b0;
                st_d.nl_valid  = 1'b1;
                st_d.nl_addr   = lk_addr;
                if (lk_ev_valid) begin
                    if (st_q.vld[victim_idx] && st_q.dty[victim_idx]) begin
                        st_d.wb_valid = 1'b1;
                        st_d.wb_addr  = st_q.tag[victim_idx];
                        st_d.wb_data  = st_q.dat[victim_idx];
                    end
                    st_d.vld[victim_idx] = 1'b1;
                    st_d.tag[victim_idx] = lk_ev_addr;
                    st_d.dat[victim_idx] = lk_ev_data;
                    st_d.dty[victim_idx] = lk_ev_dirty;
                    touch                = 1'b1;
                    touch_idx            = victim_idx;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_hit      = st_q.rsp_hit;
    assign rsp_data     = st_q.rsp_data;
    assign rsp_dirty    = st_q.rsp_dirty;
    assign nl_req_valid = st_q.nl_valid;
    assign nl_req_addr  = st_q.nl_addr;
    assign wb_valid     = st_q.wb_valid;
    assign wb_addr      = st_q.wb_addr;
    assign wb_data      = st_q.wb_data;

    // R9
    rsp_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));

    // R2
    miss_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nl_req_valid |-> rsp_valid && !rsp_hit);

    // R3
    hit_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid && !nl_req_valid);

    // R8
    wb_on_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> nl_req_valid && $past(lk_ev_valid));
endmodule

// File: tb/victim_buf_bench.sv
module victim_buf_bench;
    localparam int AW = 12;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          lk_ev_valid = 1'b0;
    logic [AW-1:0] lk_ev_addr = '0;
    logic [LW-1:0] lk_ev_data = '0;
    logic          lk_ev_dirty = 1'b0;
    logic          rsp_valid, rsp_hit, rsp_dirty, nl_req_valid, wb_valid;
    logic [LW-1:0] rsp_data, wb_data;
    logic [AW-1:0] nl_req_addr, wb_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    victim_buf u_victim_buf (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_ev_valid(lk_ev_valid), .lk_ev_addr(lk_ev_addr),
        .lk_ev_data(lk_ev_data), .lk_ev_dirty(lk_ev_dirty),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .rsp_dirty(rsp_dirty), .nl_req_valid(nl_req_valid),
        .nl_req_addr(nl_req_addr), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid = 1'b0;
        lk_ev_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive one lookup, leave outputs ready to sample at the following negedge
    task automatic lookup(input int a, input bit evv, input int ea, input logic [LW-1:0] ed, input bit edt);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr = AW'(a);
        lk_ev_valid = evv;
        lk_ev_addr = AW'(ea);
        lk_ev_data = ed;
        lk_ev_dirty = edt;
        @(negedge clk);
        lk_valid = 1'b0;
        lk_ev_valid = 1'b0;
    endtask

    task automatic expect_miss(input string req, input int a, input bit wbv, input int wa, input logic [LW-1:0] wd);
        chk(rsp_valid && !rsp_hit, req, {rsp_valid, rsp_hit}, 2'b10);
        chk(nl_req_valid && nl_req_addr == AW'(a), req, nl_req_addr, a);
        chk(wb_valid == wbv, req, wb_valid, wbv);
        if (wbv) chk(wb_addr == AW'(wa) && wb_data == wd, req, {wb_addr, wb_data}, {AW'(wa), wd});
    endtask

    task automatic expect_hit(input string req, input logic [LW-1:0] d, input bit dt);
        chk(rsp_valid && rsp_hit && !nl_req_valid, req, {rsp_valid, rsp_hit, nl_req_valid}, 3'b110);
        chk(rsp_data == d && rsp_dirty == dt, req, {rsp_data, rsp_dirty}, {d, dt});
        chk(!wb_valid, req, wb_valid, 0);
    endtask

    // behavioural models for the sweep
    bit            bv[4];
    int            ba[4];
    logic [LW-1:0] bd[4];
    bit            bdt[4];
    int            bs[4];
    int            stamp;
    bit            cv[4];
    int            ca[4];
    logic [LW-1:0] cd[4];
    bit            cdt[4];

    function automatic logic [LW-1:0] mem_line(input int a);
        return LW'(a) * 32'h9E37_79B1 + 32'h55;
    endfunction

    task automatic access(input int a, input bit wr, input logic [LW-1:0] wdat);
        int s;
        int k;
        int v;
        bit disp;
        bit ewb;
        int ewa;
        logic [LW-1:0] ewd;
        s = a % 4;
        if (cv[s] && ca[s] == a) begin
            if (wr) begin cd[s] = wdat; cdt[s] = 1; end
            return;
        end
        disp = cv[s];
        k = -1;
        for (int i = 0; i < 4; i++) if (bv[i] && ba[i] == a) k = i;
        lookup(a, disp, ca[s], cd[s], cdt[s]);
        if (k >= 0) begin
            expect_hit("R3/R4 sweep hit", bd[k], bdt[k]);
            if (disp) begin
                ba[k] = ca[s]; bd[k] = cd[s]; bdt[k] = cdt[s]; bs[k] = ++stamp;
            end else begin
                bv[k] = 0;
            end
            ca[s] = a; cd[s] = rsp_data; cdt[s] = rsp_dirty;
            cd[s] = bd[k] ^ bd[k] ^ cd[s];
        end else begin
            ewb = 0; ewa = 0; ewd = '0;
            if (disp) begin
                v = -1;
                for (int i = 3; i >= 0; i--) if (!bv[i]) v = i;
                if (v < 0) begin
                    v = 0;
                    for (int i = 1; i < 4; i++) if (bs[i] < bs[v]) v = i;
                    if (bdt[v]) begin ewb = 1; ewa = ba[v]; ewd = bd[v]; end
                end
                bv[v] = 1; ba[v] = ca[s]; bd[v] = cd[s]; bdt[v] = cdt[s]; bs[v] = ++stamp;
            end
            expect_miss("R2/R7/R8 sweep miss", a, ewb, ewa, ewd);
            ca[s] = a; cd[s] = mem_line(a); cdt[s] = 0;
        end
        cv[s] = 1;
        if (wr) begin cd[s] = wdat; cdt[s] = 1; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(!rsp_valid && !nl_req_valid && !wb_valid, "R1", {rsp_valid, nl_req_valid, wb_valid}, 0);
        lookup(16'h10, 0, 0, '0, 0);
        expect_miss("R1 R2 empty miss", 16'h10, 0, 0, '0);

        // R9 displaced line without lookup is ignored
        @(negedge clk);
        lk_ev_valid = 1; lk_ev_addr = 12'h20; lk_ev_data = 32'hBEEF; lk_ev_dirty = 1;
        @(negedge clk);
        lk_ev_valid = 0;
        chk(!rsp_valid && !nl_req_valid && !wb_valid, "R9 outputs", {rsp_valid, nl_req_valid, wb_valid}, 0);
        lookup(12'h20, 0, 0, '0, 0);
        expect_miss("R9 not stored", 12'h20, 0, 0, '0);

        // R6 fill four entries
        for (int i = 1; i <= 4; i++) begin
            lookup(12'h40 + i, 1, 12'h30 + i, 32'hA0 + i, (i % 2) == 1);
            expect_miss("R6 fill", 12'h40 + i, 0, 0, '0);
        end
        // R3 R4 swap
        lookup(12'h32, 1, 12'h35, 32'hC5, 0);
        expect_hit("R3 R4 swap hit", 32'hA2, 0);
        lookup(12'h32, 0, 0, '0, 0);
        expect_miss("R4 old line gone", 12'h32, 0, 0, '0);
        lookup(12'h35, 1, 12'h36, 32'hC6, 1);
        expect_hit("R4 swapped line", 32'hC5, 0);
        // R7 R8 full replacement, oldest first
        lookup(12'h50, 1, 12'h37, 32'hD7, 0);
        expect_miss("R7 R8 dirty oldest", 12'h50, 1, 12'h31, 32'hA1);
        lookup(12'h51, 1, 12'h38, 32'hD8, 0);
        expect_miss("R7 R8 next oldest", 12'h51, 1, 12'h33, 32'hA3);
        lookup(12'h52, 1, 12'h39, 32'hD9, 0);
        expect_miss("R8 clean no wb", 12'h52, 0, 0, '0);
        lookup(12'h31, 0, 0, '0, 0);
        expect_miss("R7 replaced gone", 12'h31, 0, 0, '0);
        // R5 hit without displaced line frees entry
        lookup(12'h36, 0, 0, '0, 0);
        expect_hit("R5 R7 kept newest", 32'hC6, 1);
        lookup(12'h36, 0, 0, '0, 0);
        expect_miss("R5 freed", 12'h36, 0, 0, '0);

        // sweep over a modelled direct-mapped cache
        do_reset();
        for (int i = 0; i < 4; i++) begin bv[i] = 0; cv[i] = 0; bs[i] = 0; end
        stamp = 0;
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(int'(lfsr[3:0]), lfsr[4], {lfsr, ~lfsr});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule